// File: doc/BRIEF.md
# Best-Offset Learning and Prefetch Engine

This block is the decision core of a best-offset prefetcher. Every demand access that it accepts tests a single candidate offset. The block asks an external recent-requests table whether the line that lies that offset behind the access was seen recently. On a hit, the candidate's score goes up. Candidates are taken in turn from a constant list, and each full pass over the list counts as one round.

When one score reaches a ceiling, or the round count reaches a limit, the engine re-evaluates. It adopts the best-scoring offset if that score beats a bad-score threshold and turns prefetching on. If no score beats the threshold, it turns prefetching off. It then clears its learning state.

While prefetching is on, each access produces a burst of prefetch line addresses, one address per handshake, at multiples of the active offset. The recent-requests table and the cache sit outside the block. One access is in flight at a time. The table answers over a request/response pair, and the prefetch addresses leave on a valid/ready stream.

Top module: `offset_learn_engine`

## Requirements
- R1: The candidate list holds the first `N_OFF` integers whose only prime factors are 2, 3 and 5, in ascending order. When `NEG_EN` is 1, each positive value is followed directly by its negation, and `N_OFF` must be even. Example: with `N_OFF`=6 and negatives enabled, the list is 1, -1, 2, -2, 3, -3.
- R2: Each accepted access tests exactly one candidate. The candidate pointer then advances by one. After the last entry the pointer returns to entry 0 and the round count goes up by one.
- R3: `lkpTag` is computed from the access address `A` and the candidate offset `o` as follows.
  - The tag of an address `X` is `(X >> LINE_LOG2)` masked to `TAG_W` bits.
  - Let `t` be the tag of `A`.
  - `lkpTag` is the tag of `(t << LINE_LOG2) - (o << LINE_LOG2)`, computed modulo 2^`ADDR_W`.
  - `lkpValid` stays high until `rspValid` arrives. `rspValid` has no effect at any other time.
- R4: On a response with `rspHit`=1, the tested candidate's score increases by one. If the new score is strictly greater than the phase best score, that candidate becomes the phase best, and its score becomes the phase best score.
- R5: Re-evaluation happens during the update of an access in either of two cases: the phase best score is at least `SCORE_MAX`, or the round count has reached `ROUND_MAX`. Re-evaluation clears the round count, all scores, the phase best score and the phase best candidate.
- R6: At re-evaluation, if the phase best score is greater than `BAD_SCORE`, `bestOffset` takes the phase best candidate's value and `pfEnable` becomes 1. Otherwise `pfEnable` becomes 0 and `bestOffset` keeps its value. `bestOffset` and `pfEnable` change at no other time.
- R7: After reset, `bestOffset` is 1, `pfEnable` is 0, `accReady` is 1, and `lkpValid` and `pfValid` are 0.
- R8: For an accepted access at address `A`, when `pfEnable` is 1 after that access's update, the block emits `DEGREE` addresses on `pfAddr`. The i-th address, for i = 1 to `DEGREE`, is `A + ((i*bestOffset) << LINE_LOG2)` modulo 2^`ADDR_W`. Addresses come in order of i, one per `pfValid`&&`pfReady` cycle. `pfAddr` holds steady while `pfReady` is low.
- R9: `accReady` is high only when no access is in flight. An access is in flight from its acceptance until its lookup has been answered and its whole burst has been sent.
- R10: The learning update of an access happens before that access's prefetches are formed. An access that triggers enabling therefore already prefetches with the newly adopted offset. An access that triggers disabling prefetches nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| accValid | input | 1 | Demand access present |
| accAddr | input | ADDR_W | Demand access byte address |
| accReady | output | 1 | Engine idle, access accepted this cycle |
| lkpValid | output | 1 | Lookup request toward the recent-requests table |
| lkpTag | output | TAG_W | Tag to look up |
| rspValid | input | 1 | Lookup response present |
| rspHit | input | 1 | Lookup found the tag |
| bestOffset | output | OFF_W | Active best offset in lines (signed) |
| pfEnable | output | 1 | Prefetch generation enabled |
| pfValid | output | 1 | Prefetch address valid |
| pfAddr | output | ADDR_W | Prefetch byte address |
| pfReady | input | 1 | Prefetch consumer ready |

## Verification
Several states are hard to reach from the ports: a phase that ends on the score ceiling partway through a round, a phase that ends on the round limit with a best score exactly equal to the threshold, and a negative best offset whose prefetches wrap below address zero. The stimulus reaches them by choosing each response's hit bit from the bench's own model of the candidate pointer. Hits are placed on one chosen candidate per round, only once in a whole phase, or on a negative candidate while the accessed addresses sit near zero. A long pseudo-random run of addresses and hit bits follows, with periodic back-pressure on the prefetch stream.

// File: rtl/olp_pkg.sv
package olp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOOKUP = 2'd1,
    ST_CHECK  = 2'd2,
    ST_ISSUE  = 2'd3
  } olp_state_t;

  // control-to-datapath strobes
  typedef struct packed {
    logic capture;     // latch the accepted access
    logic learn;       // apply the lookup result
    logic burstStart;  // load the first prefetch address
    logic burstStep;   // move to the next prefetch address
  } olp_strobe_t;

endpackage

// File: rtl/olp_ctrl.sv
module olp_ctrl
  import olp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        accValid,
  input  logic        rspValid,
  input  logic        pfReady,
  input  logic        pfEnable,
  input  logic        burstLast,
  output logic        accReady,
  output logic        lkpValid,
  output logic        pfValid,
  output olp_strobe_t strb
);

  olp_state_t state, stateNext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:   if (accValid) stateNext = ST_LOOKUP;
      ST_LOOKUP: if (rspValid) stateNext = ST_CHECK;
      ST_CHECK:  stateNext = pfEnable ? ST_ISSUE : ST_IDLE;
      ST_ISSUE:  if (pfReady && burstLast) stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  assign accReady = (state == ST_IDLE);
  assign lkpValid = (state == ST_LOOKUP);
  assign pfValid  = (state == ST_ISSUE);

  always_comb begin
    strb.capture    = (state == ST_IDLE) && accValid;
    strb.learn      = (state == ST_LOOKUP) && rspValid;
    strb.burstStart = (state == ST_CHECK) && pfEnable;
    strb.burstStep  = (state == ST_ISSUE) && pfReady && !burstLast;
  end

  // R9: an accepted access moves straight to its lookup
  a_r9_accept_to_lookup: assert property (@(posedge clk) disable iff (!rst_n)
    accValid && accReady |=> lkpValid && !accReady);

  // R3: the lookup request waits for its response
  a_r3_lookup_hold: assert property (@(posedge clk) disable iff (!rst_n)
    lkpValid && !rspValid |=> lkpValid);

  // R9: the last accepted prefetch frees the engine
  a_r9_burst_release: assert property (@(posedge clk) disable iff (!rst_n)
    pfValid && pfReady && burstLast |=> accReady && !pfValid);

endmodule

// File: rtl/olp_dpath.sv
module olp_dpath
  import olp_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LINE_LOG2 = 6,
  parameter int TAG_W     = 16,
  parameter int OFF_W     = 8,
  parameter int N_OFF     = 16,
  parameter bit NEG_EN    = 1'b0,
  parameter int SCORE_MAX = 31,
  parameter int ROUND_MAX = 100,
  parameter int BAD_SCORE = 1,
  parameter int DEGREE    = 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  olp_strobe_t              strb,
  input  logic [ADDR_W-1:0]        accAddr,
  input  logic                     rspHit,
  output logic [TAG_W-1:0]         lkpTag,
  output logic signed [OFF_W-1:0]  bestOffset,
  output logic                     pfEnable,
  output logic [ADDR_W-1:0]        pfAddr,
  output logic                     burstLast
);

  localparam int PTR_W   = (N_OFF > 1) ? $clog2(N_OFF) : 1;
  localparam int SCORE_W = $clog2(SCORE_MAX + 1);
  localparam int RND_W   = $clog2(ROUND_MAX + 1);
  localparam int CNT_W   = $clog2(DEGREE + 1);
  localparam int SEARCH  = 1024;

  // n-th candidate: smooth numbers over {2,3,5}, optionally paired with negatives
  function automatic int offsetAt(input int idx);
    int want, seen, found, m;
    want  = NEG_EN ? idx / 2 : idx;
    seen  = -1;
    found = 1;
    for (int n = 1; n <= SEARCH && seen < want; n++) begin
      m = n;
      for (int r = 0; r < 10; r++) if (m % 2 == 0) m = m / 2;
      for (int r = 0; r < 7;  r++) if (m % 3 == 0) m = m / 3;
      for (int r = 0; r < 5;  r++) if (m % 5 == 0) m = m / 5;
      if (m == 1) begin
        seen++;
        if (seen == want) found = n;
      end
    end
    return (NEG_EN && (idx % 2 == 1)) ? -found : found;
  endfunction

  function automatic logic [TAG_W-1:0] tagOf(input logic [ADDR_W-1:0] a);
    return TAG_W'(a >> LINE_LOG2);
  endfunction

  logic signed [OFF_W-1:0] offTab [N_OFF];

  for (genvar k = 0; k < N_OFF; k++) begin : g_off
    localparam int OFF_VAL = offsetAt(k);
    assign offTab[k] = OFF_W'(OFF_VAL);
  end

  logic [ADDR_W-1:0]   baseAddr;
  logic [PTR_W-1:0]    ptr;
  logic [RND_W-1:0]    round;
  logic [SCORE_W-1:0]  scores [N_OFF];
  logic [SCORE_W-1:0]  bestScore;
  logic [PTR_W-1:0]    phaseIdx;
  logic signed [OFF_W-1:0] bestOff;
  logic                enable;
  logic [ADDR_W-1:0]   pfAddrQ;
  logic [CNT_W-1:0]    burstCnt;

  // lookup tag: back to byte domain, subtract, re-extract
  logic signed [ADDR_W-1:0] curOffExt;
  logic [ADDR_W-1:0]        lkpByte;
  assign curOffExt = ADDR_W'(offTab[ptr]);
  assign lkpByte   = (ADDR_W'(tagOf(baseAddr)) << LINE_LOG2) - (curOffExt << LINE_LOG2);
  assign lkpTag    = tagOf(lkpByte);

  // learning update
  logic [SCORE_W-1:0] curScore, bumped, nb;
  logic [PTR_W-1:0]   np, ptrNext;
  logic [RND_W-1:0]   roundNext;
  logic               wrap, reeval;

  always_comb begin
    curScore  = scores[ptr];
    bumped    = (curScore == SCORE_W'(SCORE_MAX)) ? curScore : curScore + SCORE_W'(1);
    nb        = bestScore;
    np        = phaseIdx;
    if (rspHit && (bumped > bestScore)) begin
      nb = bumped;
      np = ptr;
    end
    wrap      = (ptr == PTR_W'(N_OFF - 1));
    ptrNext   = wrap ? '0 : ptr + PTR_W'(1);
    roundNext = wrap ? round + RND_W'(1) : round;
    reeval    = (nb >= SCORE_W'(SCORE_MAX)) || (roundNext >= RND_W'(ROUND_MAX));
  end

  // prefetch step in bytes
  logic signed [ADDR_W-1:0] bestOffExt;
  logic [ADDR_W-1:0]        stepAddr;
  assign bestOffExt = ADDR_W'(bestOff);
  assign stepAddr   = bestOffExt << LINE_LOG2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      baseAddr  <= '0;
      ptr       <= '0;
      round     <= '0;
      bestScore <= '0;
      phaseIdx  <= '0;
      bestOff   <= OFF_W'(1);
      enable    <= 1'b0;
      pfAddrQ   <= '0;
      burstCnt  <= '0;
      for (int k = 0; k < N_OFF; k++) scores[k] <= '0;
    end else begin
      if (strb.capture) baseAddr <= accAddr;
      if (strb.learn) begin
        if (rspHit) scores[ptr] <= bumped;
        ptr <= ptrNext;
        if (reeval) begin
          round <= '0;
          if (int'(nb) > BAD_SCORE) begin
            bestOff <= offTab[np];
            enable  <= 1'b1;
          end else begin
            enable  <= 1'b0;
          end
          for (int k = 0; k < N_OFF; k++) scores[k] <= '0;
          bestScore <= '0;
          phaseIdx  <= '0;
        end else begin
          round     <= roundNext;
          bestScore <= nb;
          phaseIdx  <= np;
        end
      end
      if (strb.burstStart) begin
        pfAddrQ  <= baseAddr + stepAddr;
        burstCnt <= CNT_W'(1);
      end else if (strb.burstStep) begin
        pfAddrQ  <= pfAddrQ + stepAddr;
        burstCnt <= burstCnt + CNT_W'(1);
      end
    end
  end

  assign bestOffset = bestOff;
  assign pfEnable   = enable;
  assign pfAddr     = pfAddrQ;
  assign burstLast  = (burstCnt == CNT_W'(DEGREE));

  // R2: pointer steps by one per learned access
  a_r2_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    strb.learn && (ptr != PTR_W'(N_OFF - 1)) |=> ptr == $past(ptr) + PTR_W'(1));

  // R2: pointer wraps after the last candidate
  a_r2_ptr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    strb.learn && (ptr == PTR_W'(N_OFF - 1)) |=> ptr == '0);

  // R6: decision outputs move only on a learning update
  a_r6_stable_between: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.learn |=> $stable(bestOffset) && $stable(pfEnable));

endmodule

// File: rtl/offset_learn_engine.sv
module offset_learn_engine
  import olp_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LINE_LOG2 = 6,
  parameter int TAG_W     = 16,
  parameter int OFF_W     = 8,
  parameter int N_OFF     = 16,
  parameter bit NEG_EN    = 1'b0,
  parameter int SCORE_MAX = 31,
  parameter int ROUND_MAX = 100,
  parameter int BAD_SCORE = 1,
  parameter int DEGREE    = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    accValid,
  input  logic [ADDR_W-1:0]       accAddr,
  output logic                    accReady,
  output logic                    lkpValid,
  output logic [TAG_W-1:0]        lkpTag,
  input  logic                    rspValid,
  input  logic                    rspHit,
  output logic signed [OFF_W-1:0] bestOffset,
  output logic                    pfEnable,
  output logic                    pfValid,
  output logic [ADDR_W-1:0]       pfAddr,
  input  logic                    pfReady
);

  olp_strobe_t strb;
  logic        burstLast;

  olp_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .accValid  (accValid),
    .rspValid  (rspValid),
    .pfReady   (pfReady),
    .pfEnable  (pfEnable),
    .burstLast (burstLast),
    .accReady  (accReady),
    .lkpValid  (lkpValid),
    .pfValid   (pfValid),
    .strb      (strb)
  );

  olp_dpath #(
    .ADDR_W    (ADDR_W),
    .LINE_LOG2 (LINE_LOG2),
    .TAG_W     (TAG_W),
    .OFF_W     (OFF_W),
    .N_OFF     (N_OFF),
    .NEG_EN    (NEG_EN),
    .SCORE_MAX (SCORE_MAX),
    .ROUND_MAX (ROUND_MAX),
    .BAD_SCORE (BAD_SCORE),
    .DEGREE    (DEGREE)
  ) u_dpath (
    .clk        (clk),
    .rst_n      (rst_n),
    .strb       (strb),
    .accAddr    (accAddr),
    .rspHit     (rspHit),
    .lkpTag     (lkpTag),
    .bestOffset (bestOffset),
    .pfEnable   (pfEnable),
    .pfAddr     (pfAddr),
    .burstLast  (burstLast)
  );

  // R8: a stalled prefetch address is held
  a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    pfValid && !pfReady |=> pfValid && $stable(pfAddr));

endmodule

// File: tb/offset_learn_engine_bench.sv
`timescale 1ns/1ps
module offset_learn_engine_bench;

  localparam int AW = 32, LL = 6, TW = 16, OW = 8;
  localparam int NO = 6, SMAX = 3, RMAX = 3, BAD = 1, DEG = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic accValid = 1'b0, rspValid = 1'b0, rspHit = 1'b0, pfReady = 1'b0;
  logic [AW-1:0] accAddr = '0;
  logic accReady, lkpValid, pfEnable, pfValid;
  logic [TW-1:0] lkpTag;
  logic signed [OW-1:0] bestOffset;
  logic [AW-1:0] pfAddr;

  always #2.5 clk = ~clk;

  offset_learn_engine #(
    .ADDR_W(AW), .LINE_LOG2(LL), .TAG_W(TW), .OFF_W(OW), .N_OFF(NO),
    .NEG_EN(1'b1), .SCORE_MAX(SMAX), .ROUND_MAX(RMAX), .BAD_SCORE(BAD), .DEGREE(DEG)
  ) u_offset_learn_engine (
    .clk(clk), .rst_n(rst_n), .accValid(accValid), .accAddr(accAddr), .accReady(accReady),
    .lkpValid(lkpValid), .lkpTag(lkpTag), .rspValid(rspValid), .rspHit(rspHit),
    .bestOffset(bestOffset), .pfEnable(pfEnable), .pfValid(pfValid), .pfAddr(pfAddr),
    .pfReady(pfReady)
  );

  int checks = 0, errors = 0;

  // reference model state
  int mOff[NO] = '{1, -1, 2, -2, 3, -3};
  int mPtr = 0, mRound = 0, mBest = 0, mPhase = 0, mBestOff = 1, mEn = 0;
  int mScore[NO] = '{0, 0, 0, 0, 0, 0};
  logic [AW-1:0] expPf[$];
  int stallCtr = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [TW-1:0] expTag(input logic [AW-1:0] a, input int off);
    logic [AW-1:0] t, x;
    t = (a >> LL) & 32'h0000_FFFF;
    x = (t << LL) - (32'(off) << LL);
    return TW'((x >> LL) & 32'h0000_FFFF);
  endfunction

  task automatic modelLearn(input logic [AW-1:0] a, input bit hit);
    if (hit) begin
      if (mScore[mPtr] < SMAX) mScore[mPtr]++;
      if (mScore[mPtr] > mBest) begin mBest = mScore[mPtr]; mPhase = mPtr; end
    end
    mPtr++;
    if (mPtr == NO) begin mPtr = 0; mRound++; end
    if (mBest >= SMAX || mRound >= RMAX) begin
      mRound = 0;
      if (mBest > BAD) begin mBestOff = mOff[mPhase]; mEn = 1; end
      else mEn = 0;
      for (int k = 0; k < NO; k++) mScore[k] = 0;
      mBest = 0; mPhase = 0;
    end
    if (mEn != 0)
      for (int i = 1; i <= DEG; i++) expPf.push_back(a + (32'(i * mBestOff) << LL));
  endtask

  task automatic doAccess(input logic [AW-1:0] a, input bit hit);
    logic [TW-1:0] et;
    while (!accReady) @(negedge clk);
    et = expTag(a, mOff[mPtr]);
    accValid = 1'b1; accAddr = a;
    @(negedge clk);
    accValid = 1'b0;
    chk(lkpValid == 1'b1 && accReady == 1'b0, "R9 lookup follows accept", {lkpValid, accReady}, 2'b10);
    chk(lkpTag == et, "R1 R2 R3 lookup tag", lkpTag, et);
    @(negedge clk);
    chk(lkpValid == 1'b1, "R3 lookup held without response", lkpValid, 1);
    rspValid = 1'b1; rspHit = hit;
    @(negedge clk);
    rspValid = 1'b0; rspHit = 1'b0;
    modelLearn(a, hit);
    forever begin
      chk(int'(bestOffset) == mBestOff && int'(pfEnable) == mEn, "R4 R5 R6 decision",
          {int'(bestOffset), 31'd0, pfEnable}, {mBestOff, 31'd0, mEn[0]});
      chk(!(accReady && (pfValid || lkpValid)), "R9 single access", {accReady, pfValid, lkpValid}, 0);
      if (accReady) break;
      if (pfValid) begin
        stallCtr++;
        if (stallCtr % 3 == 1) pfReady = 1'b0;
        else begin
          if (expPf.size() == 0) chk(1'b0, "R8 unexpected prefetch", pfAddr, 0);
          else begin
            chk(pfAddr == expPf[0], "R8 R10 prefetch address", pfAddr, expPf[0]);
            void'(expPf.pop_front());
          end
          pfReady = 1'b1;
        end
      end else pfReady = 1'b0;
      @(negedge clk);
    end
    pfReady = 1'b0;
    chk(expPf.size() == 0, "R8 burst length", expPf.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] lf;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R7 reset state
    chk(int'(bestOffset) == 1, "R7 reset offset", int'(bestOffset), 1);
    chk(pfEnable == 1'b0, "R7 reset enable", pfEnable, 0);
    chk(accReady && !lkpValid && !pfValid, "R7 reset handshakes", {accReady, lkpValid, pfValid}, 3'b100);

    // stray response while idle must be ignored (R3)
    rspValid = 1'b1; rspHit = 1'b1;
    @(negedge clk);
    rspValid = 1'b0; rspHit = 1'b0;
    chk(accReady && !pfEnable && int'(bestOffset) == 1, "R3 stray response ignored",
        {accReady, pfEnable}, 2'b10);

    // phase of misses: round limit, stays disabled (R5)
    for (int k = 0; k < NO * RMAX; k++) doAccess(32'h0000_1000 + 32'(k) * 32'h40, 1'b0);

    // hits on candidate 3 once per round: ceiling reached, enable (R4 R6 R10)
    for (int k = 0; k < NO * RMAX; k++) doAccess(32'h0004_0000 + 32'(k) * 32'h100, mPtr == 4);
    chk(mEn == 1 && int'(bestOffset) == 3, "R6 adopted offset 3", int'(bestOffset), 3);
    for (int k = 0; k < NO * RMAX; k++) doAccess(32'h0008_0010 + 32'(k) * 32'h40, 1'b0);

    // negative best offset near address zero: wrap below zero (R8)
    for (int k = 0; k < NO * RMAX; k++) doAccess(32'h0000_0040 + 32'(k % 2) * 32'h40, mPtr == 3);
    for (int k = 0; k < 8; k++) doAccess(32'h0000_0005 + 32'(k) * 32'h40, 1'b0);

    // single hit in a phase: score equals threshold, disabled (R6)
    for (int k = 0; k < NO * RMAX * 2; k++) doAccess(32'h0010_0000 + 32'(k) * 32'h40,
                                                    (k == 0) || (mPtr == 1 && k < NO));
    chk(pfEnable == 1'b0, "R6 threshold not exceeded", pfEnable, 0);

    // pseudo-random run
    lf = 32'hACE1_1357;
    for (int k = 0; k < 200; k++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      doAccess(lf, lf[5] & lf[9]);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule